// File: doc/BRIEF.md
# Misaligned Access Splitter for an Aligned 64-bit Bus

This block sits between a load/store unit and a 64-bit data bus that only accepts transactions at 8-byte-aligned addresses. Each request carries a byte address, a size code, a write flag, a sign-extension flag and, for stores, the data. If the access stays inside one aligned 8-byte block, the splitter issues a single bus beat. Lane strobes mark the touched bytes. If the access crosses into the next block, it issues two beats. The beat at the lower address goes first and the next block follows. Each beat enables only the lanes that belong to it.

For loads, the splitter collects the returned bytes from one or two beats. It reorders them in little-endian order, right-aligns the result and fills the upper bits with zeros or with copies of the sign bit. It accepts one request at a time and raises a single-cycle response once the last beat has been accepted.

The control is a four-state machine:
- **IDLE** accepts a request and moves to LOW.
- **LOW** drives the first beat. When that beat is accepted, it moves to HIGH if the access crosses a block boundary, or to DONE otherwise.
- **HIGH** drives the second beat and moves to DONE when it is accepted.
- **DONE** presents the response for one cycle and returns to IDLE.

Top module: `lsu_split_bridge`

## Requirements
- R1: Every bus beat carries an address whose three low bits are zero. The byte position inside the block is expressed only by `bus_strb`, where bit k enables byte lane k (bits 8k+7:8k of the data).
- R2: An access of n bytes at block offset o with o+n ≤ 8 produces exactly one beat. That beat goes to the aligned block address with strobe lanes o through o+n−1 set. For example, 2 bytes at offset 1 gives strobe 0x06.
- R3: An access with o+n > 8 produces exactly two beats. The first goes to the aligned block with lanes o..7 set. The second goes to that address plus 8 with lanes 0..(o+n−9) set. For example, an 8-byte access at 0x104 gives 0x100/strobe 0xF0 followed by 0x108/strobe 0x0F.
- R4: A store places data byte i at memory address addr+i, that is, on lane (o+i) mod 8 of the beat covering it. Lanes without a strobe are not written.
- R5: A load assembles byte i of the result from address addr+i in little-endian order, across both beats if needed. Lanes without a strobe are ignored. For example, with 0x34,0x12,0x78,0x56 at 0x100..0x103, a 2-byte load at 0x101 returns 0x7812.
- R6: The size code in `req_size` maps 0, 1, 2, 3 to 1, 2, 4, 8 bytes. A 1-byte access never splits and enables exactly one lane.
- R7: Load bits above the access size are zero when `req_signed` is 0. When it is 1, they are copies of the top bit of the most significant loaded byte.
- R8: `rsp_valid` is high for exactly one cycle, in the cycle after the last beat is accepted, and never before all beats of the access are done.
- R9: `req_ready` drops after a request is accepted and stays low until the response cycle has passed, so a new request is held off while an access is in flight.
- R10: While `bus_valid` is high and `bus_ready` is low, address, strobe, write flag and write data stay stable.
- R11: After reset the splitter is idle: `req_ready` high, `bus_valid` low, `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Splitter can take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Size code, bytes = 1 << code |
| req_signed | input | 1 | Sign-extend load result |
| req_wdata | input | 64 | Store data, right-aligned |
| rsp_valid | output | 1 | Access complete (one cycle) |
| rsp_rdata | output | 64 | Right-aligned, extended load result |
| bus_valid | output | 1 | Bus beat request |
| bus_ready | input | 1 | Bus accepts the beat |
| bus_write | output | 1 | Beat direction |
| bus_addr | output | ADDR_W | Aligned beat address |
| bus_strb | output | 8 | Byte lane enables |
| bus_wdata | output | 64 | Lane-positioned store data |
| bus_rdata | input | 64 | Read data, valid with bus_ready |

## Verification
The bench sweeps every size against every byte offset over two consecutive blocks. It issues a store, a zero-extended load and a sign-extended load for each combination. This separates accesses that fit in one block from those that straddle the boundary, and it catches lane mistakes at every alignment. The bus model fills unstrobed read lanes with inverted bytes, so any leakage from ignored lanes shows up in the result. Throttled `bus_ready` exercises the hold rules. Hand-picked cases then pin the documented examples: the byte-swapped 16-bit read, the 8-byte store at offset 4, and negative versus positive byte loads.

// File: rtl/lsu_split_pkg.sv
package lsu_split_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } split_state_e;

    function automatic int size_to_bytes(input logic [1:0] code);
        return 1 << code;
    endfunction

endpackage

// File: rtl/split_lane_plan.sv
module split_lane_plan #(
    parameter int LANES = 8,
    localparam int OFF_W = $clog2(LANES),
    localparam int DW    = LANES * 8
) (
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       size,
    input  logic [DW-1:0]    wdata,
    output logic [LANES-1:0] strb_lo,
    output logic [LANES-1:0] strb_hi,
    output logic [DW-1:0]    data_lo,
    output logic [DW-1:0]    data_hi,
    output logic             crosses
);
    import lsu_split_pkg::*;

    logic [LANES-1:0]   used;
    logic [DW-1:0]      wkeep;
    logic [2*LANES-1:0] mask;
    logic [2*DW-1:0]    wide;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            used[i]          = (i < size_to_bytes(size));
            wkeep[i*8 +: 8]  = used[i] ? wdata[i*8 +: 8] : 8'h00;
        end
        mask    = {{LANES{1'b0}}, used} << off;
        wide    = {{DW{1'b0}}, wkeep} << {off, 3'b000};
        strb_lo = mask[LANES-1:0];
        strb_hi = mask[2*LANES-1:LANES];
        data_lo = wide[DW-1:0];
        data_hi = wide[2*DW-1:DW];
        crosses = |strb_hi;
    end

endmodule

// File: rtl/split_load_merge.sv
module split_load_merge #(
    parameter int LANES = 8,
    localparam int OFF_W = $clog2(LANES),
    localparam int DW    = LANES * 8
) (
    input  logic [2*DW-1:0]  gathered,
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       size,
    input  logic             sign_ext,
    output logic [DW-1:0]    result
);
    import lsu_split_pkg::*;

    logic [2*DW-1:0] shifted;
    logic            top_bit;
    int              nb;

    always_comb begin
        nb      = size_to_bytes(size);
        shifted = gathered >> {off, 3'b000};
        top_bit = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (i == nb - 1) top_bit = shifted[i*8 + 7];
        end
        for (int i = 0; i < LANES; i++) begin
            if (i < nb) result[i*8 +: 8] = shifted[i*8 +: 8];
            else        result[i*8 +: 8] = {8{sign_ext & top_bit}};
        end
    end

endmodule

// File: rtl/lsu_split_bridge.sv
module lsu_split_bridge #(
    parameter int ADDR_W = 32,
    parameter int LANES  = 8,
    localparam int OFF_W = $clog2(LANES),
    localparam int DW    = LANES * 8,
    localparam int BLK_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic [DW-1:0]     req_wdata,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_rdata,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [LANES-1:0]  bus_strb,
    output logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_rdata
);
    import lsu_split_pkg::*;

    split_state_e      state, state_nx;
    logic [BLK_W-1:0]  blk_q;
    logic [OFF_W-1:0]  off_q;
    logic [1:0]        size_q;
    logic              sext_q;
    logic              write_q;
    logic [DW-1:0]     wdata_q;
    logic [2*DW-1:0]   gather_q;

    logic [LANES-1:0]  strb_lo, strb_hi;
    logic [DW-1:0]     data_lo, data_hi;
    logic              crosses;
    logic              beat_done;

    split_lane_plan #(.LANES(LANES)) u_plan (
        .off     (off_q),
        .size    (size_q),
        .wdata   (wdata_q),
        .strb_lo (strb_lo),
        .strb_hi (strb_hi),
        .data_lo (data_lo),
        .data_hi (data_hi),
        .crosses (crosses)
    );

    split_load_merge #(.LANES(LANES)) u_merge (
        .gathered (gather_q),
        .off      (off_q),
        .size     (size_q),
        .sign_ext (sext_q),
        .result   (rsp_rdata)
    );

    assign beat_done = bus_valid && bus_ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_LOW;
            ST_LOW:  if (beat_done) state_nx = crosses ? ST_HIGH : ST_DONE;
            ST_HIGH: if (beat_done) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            blk_q    <= '0;
            off_q    <= '0;
            size_q   <= '0;
            sext_q   <= 1'b0;
            write_q  <= 1'b0;
            wdata_q  <= '0;
            gather_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && req_valid) begin
                blk_q   <= req_addr[ADDR_W-1:OFF_W];
                off_q   <= req_addr[OFF_W-1:0];
                size_q  <= req_size;
                sext_q  <= req_signed;
                write_q <= req_write;
                wdata_q <= req_wdata;
            end
            if (state == ST_LOW && beat_done)  gather_q[DW-1:0]    <= bus_rdata;
            if (state == ST_HIGH && beat_done) gather_q[2*DW-1:DW] <= bus_rdata;
        end
    end

    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_valid = (state == ST_DONE);
        bus_valid = (state == ST_LOW) || (state == ST_HIGH);
        bus_write = write_q;
        bus_addr  = {blk_q + {{(BLK_W-1){1'b0}}, (state == ST_HIGH)}, {OFF_W{1'b0}}};
        bus_strb  = '0;
        bus_wdata = '0;
        unique case (state)
            ST_LOW:  begin bus_strb = strb_lo; bus_wdata = data_lo; end
            ST_HIGH: begin bus_strb = strb_hi; bus_wdata = data_hi; end
            default: ;
        endcase
    end

    // R1
    bus_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_addr[OFF_W-1:0] == '0));

    // R2
    strb_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_strb != '0));

    // R3
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW && beat_done && crosses) |=>
            (bus_valid && bus_addr == $past(bus_addr) + ADDR_W'(LANES)));

    // R6
    one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && size_q == 2'd0) |-> ($countones(bus_strb) == 1 && state == ST_LOW));

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R9
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=>
            (bus_valid && $stable(bus_addr) && $stable(bus_strb)
             && $stable(bus_wdata) && $stable(bus_write)));

endmodule

// File: tb/lsu_split_bridge_tb.sv
module lsu_split_bridge_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_signed = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        bus_valid;
    logic        bus_ready = 1'b0;
    logic        bus_write;
    logic [31:0] bus_addr;
    logic [7:0]  bus_strb;
    logic [63:0] bus_wdata;
    logic [63:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0]  mem [32];
    logic [7:0]  ref_mem [32];
    int          beat_total = 0;
    logic [31:0] log_addr [4];
    logic [7:0]  log_strb [4];
    int          rdy_cnt = 0;

    logic [31:0] got_addr0, got_addr1;
    logic [7:0]  got_strb0, got_strb1;
    int          got_beats;
    logic [63:0] got_data;

    always #2 clk = ~clk;

    lsu_split_bridge u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_signed(req_signed),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_strb(bus_strb), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] init_byte(input int i);
        return 8'(i * 37 + 5);
    endfunction

    always @(negedge clk) begin
        rdy_cnt <= rdy_cnt + 1;
        bus_ready <= ((rdy_cnt % 3) != 0);
    end

    always @* begin
        for (int l = 0; l < 8; l++) begin
            logic [31:0] idx;
            logic [7:0]  b;
            idx = bus_addr - 32'h100 + 32'(l);
            b   = (idx < 32) ? mem[idx[4:0]] : 8'h00;
            bus_rdata[l*8 +: 8] = bus_strb[l] ? b : ~b;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) mem[i] <= init_byte(i);
            beat_total <= 0;
        end else if (bus_valid && bus_ready) begin
            log_addr[beat_total % 4] <= bus_addr;
            log_strb[beat_total % 4] <= bus_strb;
            beat_total <= beat_total + 1;
            if (bus_write) begin
                for (int l = 0; l < 8; l++) begin
                    logic [31:0] wi;
                    wi = bus_addr - 32'h100 + 32'(l);
                    if (bus_strb[l] && wi < 32) mem[wi[4:0]] <= bus_wdata[l*8 +: 8];
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input int off, input int sz, input bit sx,
                          input logic [63:0] wd);
        int  start;
        bit  held_bad;
        start    = beat_total;
        held_bad = 1'b0;
        check(req_ready == 1'b1, "R9 ready before request", 64'(req_ready), 64'd1);
        req_valid  = 1'b1;
        req_write  = wr;
        req_addr   = 32'h100 + 32'(off);
        req_size   = 2'(sz);
        req_signed = sx;
        req_wdata  = wd;
        @(negedge clk);
        req_valid = 1'b0;
        for (int w = 0; w < 60 && !rsp_valid; w++) begin
            if (req_ready) held_bad = 1'b1;
            @(negedge clk);
        end
        check(rsp_valid == 1'b1, "R8 response arrives", 64'(rsp_valid), 64'd1);
        check(!held_bad, "R9 request held off while busy", 64'(held_bad), 64'd0);
        got_data  = rsp_rdata;
        got_beats = beat_total - start;
        got_addr0 = log_addr[start % 4];
        got_strb0 = log_strb[start % 4];
        got_addr1 = log_addr[(start + 1) % 4];
        got_strb1 = log_strb[(start + 1) % 4];
        @(negedge clk);
        check(rsp_valid == 1'b0, "R8 single-cycle response", 64'(rsp_valid), 64'd0);
    endtask

    task automatic run_case(input bit wr, input int off, input int sz, input bit sx,
                            input logic [63:0] wd);
        int          n;
        logic [7:0]  exp_lo, exp_hi;
        logic [63:0] exp_val;
        bit          same;
        n      = 1 << sz;
        exp_lo = '0;
        exp_hi = '0;
        for (int i = 0; i < n; i++) begin
            int b;
            b = 32'h100 + off + i;
            if ((b >> 3) == ((32'h100 + off) >> 3)) exp_lo[b % 8] = 1'b1;
            else                                    exp_hi[b % 8] = 1'b1;
        end
        access(wr, off, sz, sx, wd);
        if (exp_hi == 0) begin
            check(got_beats == 1 && got_addr0 == ((32'h100 + off) & ~32'h7) && got_strb0 == exp_lo,
                  (sz == 0) ? "R6 single byte one beat" : "R2 one beat",
                  {got_addr0, 16'(got_beats), got_strb0, 8'h0},
                  {(32'h100 + 32'(off)) & ~32'h7, 16'd1, exp_lo, 8'h0});
        end else begin
            check(got_beats == 2 && got_addr0 == ((32'h100 + off) & ~32'h7)
                  && got_addr1 == got_addr0 + 8 && got_strb0 == exp_lo && got_strb1 == exp_hi,
                  "R3 two beats", {got_addr0[15:0], got_addr1[15:0], got_strb0, got_strb1, 16'(got_beats)},
                  {16'((32'h100 + off) & ~32'h7), 16'(((32'h100 + off) & ~32'h7) + 8), exp_lo, exp_hi, 16'd2});
        end
        if (wr) begin
            for (int i = 0; i < n; i++) ref_mem[off + i] = wd[i*8 +: 8];
            same = 1'b1;
            for (int i = 0; i < 32; i++) if (mem[i] !== ref_mem[i]) same = 1'b0;
            check(same, "R4 store lanes", 64'(same), 64'd1);
        end else begin
            exp_val = '0;
            for (int i = 0; i < n; i++) exp_val[i*8 +: 8] = ref_mem[off + i];
            if (sx && ref_mem[off + n - 1][7])
                for (int i = n; i < 8; i++) exp_val[i*8 +: 8] = 8'hFF;
            check(got_data == exp_val, sx ? "R7 signed load" : "R5 load assembly",
                  got_data, exp_val);
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) ref_mem[i] = init_byte(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !bus_valid && !rsp_valid, "R11 reset state",
              {61'd0, req_ready, bus_valid, rsp_valid}, 64'd4);

        for (int sz = 0; sz < 4; sz++) begin
            for (int off = 0; off < 16; off++) begin
                logic [63:0] wd;
                for (int i = 0; i < 8; i++) wd[i*8 +: 8] = 8'((sz * 16 + off) * 29 + i * 71 + 3);
                run_case(1'b1, off, sz, 1'b0, wd);
                run_case(1'b0, off, sz, 1'b0, 64'h0);
                run_case(1'b0, off, sz, 1'b1, 64'h0);
            end
        end

        run_case(1'b1, 0, 2, 1'b0, 64'h0000_0000_5678_1234);
        run_case(1'b0, 1, 1, 1'b0, 64'h0);
        check(got_data == 64'h7812, "R5 byte-swapped halfword", got_data, 64'h7812);

        run_case(1'b1, 4, 3, 1'b0, 64'h8877_6655_4433_2211);
        check(got_addr0 == 32'h100 && got_strb0 == 8'hF0 && got_addr1 == 32'h108
              && got_strb1 == 8'h0F, "R3 eight bytes at 0x104",
              {got_addr0[15:0], got_strb0, got_addr1[15:0], got_strb1, 16'h0},
              {16'h0100, 8'hF0, 16'h0108, 8'h0F, 16'h0});

        run_case(1'b1, 3, 0, 1'b0, 64'h80);
        run_case(1'b0, 3, 0, 1'b1, 64'h0);
        check(got_data == 64'hFFFF_FFFF_FFFF_FF80, "R7 negative byte", got_data,
              64'hFFFF_FFFF_FFFF_FF80);
        run_case(1'b0, 3, 0, 1'b0, 64'h0);
        check(got_data == 64'h80, "R7 zero-extended byte", got_data, 64'h80);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
            $finish;
        end
    end

endmodule